// File: doc/BRIEF.md
# RMII Receive Dibit Output Stage

This block is the PHY-side output stage of a reduced-pin receive path. Each decoded 4-bit nibble goes into a small elastic queue. The block then sends each nibble as two 2-bit dibits on `rxd_o`. The least significant pair goes first. A single line, `crs_dv_o`, carries both carrier presence and data validity. Everything runs on the 50 MHz reference clock. At 100 Mb/s the stage sends one dibit per clock. At 10 Mb/s it holds each dibit for a configurable number of clocks, ten by default.

The line rises on the first clock that sees carrier. While carrier is up, it stays high whether data is flowing or not. When carrier ends, the line may only drop at the start of a first-dibit slot. If nibbles are still queued at that point, the line goes low in each first-dibit slot and high in each second-dibit slot until the queue is empty. A MAC can therefore recover carrier and data-valid as two separate signals. A carrier with no decoded data shows as `crs_dv_o` high with `rxd_o` at 00. A per-nibble decode error can be passed out on `rx_er_o`, and this output can be removed by a parameter.

The upstream decoder pushes one nibble per valid strobe while carrier is present. The speed selection is sampled only between receive events.

Top module: `rmii_rx_dibit_tx`

## Requirements
- R1: While reset is low, and after reset until carrier is seen, `crs_dv_o`, `rxd_o` and `rx_er_o` are all 0.
- R2: `crs_dv_o` is 1 after every clock edge that samples `car_i` high, whatever the dibit slot phase.
- R3: When no queued nibble is available at a first-dibit slot, `rxd_o` is 00 for that slot and the next slot is again a first-dibit slot. A nibble therefore always begins on a first-dibit slot, and an event always starts with `rxd_o` = 00.
- R4: A nibble b3..b0 is sent as `rxd_o` = b1b0 in its first slot and b3b2 in its second. At 100 Mb/s (`spd10_i` = 0) each slot lasts one clock.
- R5: `crs_dv_o` only falls at the start of a first-dibit slot. A carrier loss during a second-dibit slot leaves the line high until that slot ends.
- R6: With carrier absent and nibbles still queued, `crs_dv_o` is 0 during each first-dibit slot and 1 during each second-dibit slot.
- R7: At the first first-dibit slot that finds the queue empty and carrier absent, `crs_dv_o` and `rxd_o` return to 0. The block is then idle.
- R8: A carrier with no nibbles keeps `crs_dv_o` at 1 for its whole duration, with `rxd_o` = 00.
- R9: At 10 Mb/s (`spd10_i` = 1) each slot lasts SLOW_DIV (10) clocks counted from the edge that starts the event. `rxd_o` and the falls of `crs_dv_o` change only at slot boundaries. A drain toggle therefore has a period of 2×SLOW_DIV clocks.
- R10: `spd10_i` is sampled only while idle. A change during an event has no effect until the event ends.
- R11: A nibble strobed while `car_i` is low is discarded and never appears on `rxd_o`.
- R12: `rx_er_o` equals the error flag of the nibble being sent, for both of its slots, and is 0 otherwise. With EN_RXER = 0 it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spd10_i | input | 1 | 1 selects 10 Mb/s slot timing, 0 selects 100 Mb/s |
| car_i | input | 1 | Carrier detected by the line decoder |
| nib_vld_i | input | 1 | Decoded nibble strobe |
| nib_i | input | 4 | Decoded nibble |
| nib_err_i | input | 1 | Decode error flag for `nib_i` |
| rxd_o | output | 2 | Receive dibit to the MAC |
| crs_dv_o | output | 1 | Combined carrier and data-valid |
| rx_er_o | output | 1 | Receive error for the nibble in flight |

## Verification
All outputs are registered, so a stimulus sampled at one rising edge shows up after that same edge. The bench drives inputs at the falling edge and reads outputs at the next falling edge. At 100 Mb/s, the first slot starts at the edge that sees carrier, and every later edge starts a new slot. The table therefore lists one expected output triple per clock. At 10 Mb/s, slot boundaries fall on edges 10, 20, 30… after the edge that started the event. The directed tests check the cycle before and the cycle after each of these edges. They also check the R2 rise in the middle of a slot, one edge after carrier returns.

// File: rtl/rmii_rx_pkg.sv
// Shared widths and the queued-nibble record for the RMII receive output stage.
package rmii_rx_pkg;

    localparam int NIB_W   = 4;
    localparam int DIBIT_W = 2;

    // One decoded nibble plus its decode error flag.
    typedef struct packed {
        logic             err;
        logic [NIB_W-1:0] data;
    } rx_nib_t;

endpackage

// File: rtl/rmii_rx_nibfifo.sv
// Elastic nibble queue between the line decoder and the dibit serializer.
// Assumes: a push when full is dropped; a pop when empty is ignored;
// read data is the head entry, visible combinationally.
module rmii_rx_nibfifo
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  rx_nib_t                       wr_nib_i,
    input  logic                          rd_en_i,
    output rx_nib_t                       rd_nib_o,
    output logic                          empty_o,
    output logic [$clog2(DEPTH+1)-1:0]    level_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    rx_nib_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [LW-1:0] cnt_q;
    logic          wr_ok, rd_ok;

    // Qualify requests against the fill state.
    always_comb begin
        wr_ok = wr_en_i && (cnt_q != LVL_FULL);
        rd_ok = rd_en_i && (cnt_q != '0);
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr_q] <= wr_nib_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Head entry and status.
    always_comb begin
        rd_nib_o = mem[rd_ptr_q];
        empty_o  = (cnt_q == '0);
        level_o  = cnt_q;
    end

endmodule

// File: rtl/rmii_rx_slottmr.sv
// Dibit slot timer. Marks the last clock of each dibit slot while an event runs.
// Assumes: run_i rises at the edge that starts the first slot, so the counter
// starts from zero; at 100 Mb/s every clock ends a slot.
module rmii_rx_slottmr #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    output logic slot_last_o
);

    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Slot end: each clock when fast, terminal count when slow.
    always_comb begin
        slot_last_o = run_i && (!slow_i || (cnt_q == CNT_LAST));
    end

    // Clocks-into-slot counter, cleared while idle and at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || slot_last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rmii_rx_crsenc.sv
// Dibit serializer and combined carrier/data-valid encoder.
// Assumes: the queue holds only nibbles pushed under carrier; the speed input
// is captured only while idle; slot_last_i comes from the slot timer running
// off active_o.
module rmii_rx_crsenc
    import rmii_rx_pkg::*;
#(
    parameter bit EN_RXER = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               car_i,
    input  logic               spd_i,
    input  logic               slot_last_i,
    input  logic               fifo_empty_i,
    input  rx_nib_t            fifo_nib_i,
    output logic               fifo_pop_o,
    output logic               active_o,
    output logic               phase_hi_o,
    output logic               spd_q_o,
    output logic [DIBIT_W-1:0] rxd_o,
    output logic               crs_dv_o,
    output logic               rx_er_o
);

    logic               active_q;
    logic               phase_hi_q;
    logic               spd_q;
    logic [DIBIT_W-1:0] rxd_q;
    logic [DIBIT_W-1:0] hi_dibit_q;
    logic               crs_q;
    logic               er_q;
    logic               hi_er_q;

    // Pop the head nibble at a first-slot boundary when one is queued.
    always_comb begin
        fifo_pop_o = active_q && slot_last_i && !phase_hi_q && !fifo_empty_i;
    end

    // Event state machine: idle entry, slot sequencing, CRS_DV encoding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            phase_hi_q <= 1'b0;
            spd_q      <= 1'b0;
            rxd_q      <= '0;
            hi_dibit_q <= '0;
            crs_q      <= 1'b0;
            er_q       <= 1'b0;
            hi_er_q    <= 1'b0;
        end else if (!active_q) begin
            spd_q      <= spd_i;
            phase_hi_q <= 1'b0;
            rxd_q      <= '0;
            er_q       <= 1'b0;
            crs_q      <= car_i;
            active_q   <= car_i;
        end else if (slot_last_i) begin
            if (phase_hi_q) begin
                rxd_q      <= hi_dibit_q;
                er_q       <= hi_er_q;
                phase_hi_q <= 1'b0;
                crs_q      <= 1'b1;
            end else if (!fifo_empty_i) begin
                rxd_q      <= fifo_nib_i.data[DIBIT_W-1:0];
                hi_dibit_q <= fifo_nib_i.data[NIB_W-1:DIBIT_W];
                er_q       <= fifo_nib_i.err;
                hi_er_q    <= fifo_nib_i.err;
                phase_hi_q <= 1'b1;
                crs_q      <= car_i;
            end else begin
                rxd_q    <= '0;
                er_q     <= 1'b0;
                crs_q    <= car_i;
                active_q <= car_i;
            end
        end else if (car_i) begin
            crs_q <= 1'b1;
        end
    end

    // Output mapping; the error pin is removed when the parameter is clear.
    always_comb begin
        active_o   = active_q;
        phase_hi_o = phase_hi_q;
        spd_q_o    = spd_q;
        rxd_o      = rxd_q;
        crs_dv_o   = crs_q;
        rx_er_o    = EN_RXER ? er_q : 1'b0;
    end

endmodule

// File: rtl/rmii_rx_dibit_tx.sv
// Top of the RMII receive output stage: nibble queue, slot timer, encoder.
// Assumes: one 50 MHz clock for everything; nibbles arrive only while carrier
// is up (others are discarded); the speed input is static within an event.
module rmii_rx_dibit_tx
    import rmii_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int SLOW_DIV   = 10,
    parameter bit EN_RXER    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spd10_i,
    input  logic               car_i,
    input  logic               nib_vld_i,
    input  logic [NIB_W-1:0]   nib_i,
    input  logic               nib_err_i,
    output logic [DIBIT_W-1:0] rxd_o,
    output logic               crs_dv_o,
    output logic               rx_er_o
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    rx_nib_t            wr_nib;
    rx_nib_t            head_nib;
    logic               push;
    logic               pop;
    logic               fifo_empty;
    logic [LVL_W-1:0]   fifo_lvl;
    logic               active;
    logic               phase_hi;
    logic               spd_q;
    logic               slot_last;

    // Accept decoded nibbles only under carrier.
    always_comb begin
        push        = nib_vld_i && car_i;
        wr_nib.err  = nib_err_i;
        wr_nib.data = nib_i;
    end

    rmii_rx_nibfifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (push),
        .wr_nib_i (wr_nib),
        .rd_en_i  (pop),
        .rd_nib_o (head_nib),
        .empty_o  (fifo_empty),
        .level_o  (fifo_lvl)
    );

    rmii_rx_slottmr #(
        .SLOW_DIV (SLOW_DIV)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (active),
        .slow_i      (spd_q),
        .slot_last_o (slot_last)
    );

    rmii_rx_crsenc #(
        .EN_RXER (EN_RXER)
    ) u_enc (
        .clk          (clk),
        .rst_n        (rst_n),
        .car_i        (car_i),
        .spd_i        (spd10_i),
        .slot_last_i  (slot_last),
        .fifo_empty_i (fifo_empty),
        .fifo_nib_i   (head_nib),
        .fifo_pop_o   (pop),
        .active_o     (active),
        .phase_hi_o   (phase_hi),
        .spd_q_o      (spd_q),
        .rxd_o        (rxd_o),
        .crs_dv_o     (crs_dv_o),
        .rx_er_o      (rx_er_o)
    );

endmodule

// File: rtl/rmii_rx_dibit_chk.sv
// Protocol checker for the RMII receive output stage, bound into the top.
module rmii_rx_dibit_chk #(
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          car_i,
    input logic          crs_dv_o,
    input logic [1:0]    rxd_o,
    input logic          rx_er_o,
    input logic          slot_last,
    input logic          phase_hi,
    input logic          active,
    input logic [LW-1:0] fifo_lvl
);

    // R2: carrier sampled high forces CRS_DV high after that edge.
    assert_carrier_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        car_i |=> crs_dv_o);

    // R3: an event starting from idle opens with a zero dibit.
    assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(crs_dv_o) && !$past(active)) |-> (rxd_o == 2'b00));

    // R5: without carrier, CRS_DV cannot fall away from a slot boundary.
    assert_fall_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (crs_dv_o && !slot_last) |=> crs_dv_o);

    // R6: a second-dibit slot always carries CRS_DV high.
    assert_second_slot_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_last && phase_hi) |=> crs_dv_o);

    // R9: the dibit only changes at slot boundaries.
    assert_dibit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_last |=> $stable(rxd_o));

    // R11: without carrier the queue never grows.
    assert_no_push_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !car_i |=> (fifo_lvl <= $past(fifo_lvl)));

    // R12: receive error appears only inside an event.
    assert_rxer_in_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er_o |-> active);

endmodule

bind rmii_rx_dibit_tx rmii_rx_dibit_chk #(
    .LW (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .car_i     (car_i),
    .crs_dv_o  (crs_dv_o),
    .rxd_o     (rxd_o),
    .rx_er_o   (rx_er_o),
    .slot_last (slot_last),
    .phase_hi  (phase_hi),
    .active    (active),
    .fifo_lvl  (fifo_lvl)
);

// File: tb/tb_rmii_rx_dibit_tx.sv
// Self-checking bench: a 100 Mb/s vector table, then directed 10 Mb/s and reset cases.
module tb_rmii_rx_dibit_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       spd10;
    logic       car;
    logic       vld;
    logic [3:0] nib;
    logic       nerr;
    logic [1:0] rxd, rxd_n;
    logic       crs, crs_n;
    logic       er, er_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rmii_rx_dibit_tx dut (
        .clk (clk), .rst_n (rst_n), .spd10_i (spd10), .car_i (car),
        .nib_vld_i (vld), .nib_i (nib), .nib_err_i (nerr),
        .rxd_o (rxd), .crs_dv_o (crs), .rx_er_o (er)
    );

    rmii_rx_dibit_tx #(.EN_RXER (1'b0)) dut_noer (
        .clk (clk), .rst_n (rst_n), .spd10_i (spd10), .car_i (car),
        .nib_vld_i (vld), .nib_i (nib), .nib_err_i (nerr),
        .rxd_o (rxd_n), .crs_dv_o (crs_n), .rx_er_o (er_n)
    );

    // Row layout: {car, vld, nib[3:0], err, exp_crs, exp_rxd[1:0], exp_er}
    localparam int NROWS = 24;
    localparam logic [10:0] TBL [NROWS] = '{
        11'b1_1_1001_0_1_00_0,  // 0  R2 R3 event opens, zero dibit
        11'b1_1_0110_1_1_01_0,  // 1  R4 low pair of 1001
        11'b1_1_1100_0_1_10_0,  // 2  R4 high pair of 1001
        11'b0_0_0000_0_0_10_1,  // 3  R6 R12 carrier gone, data queued
        11'b0_0_0000_0_1_01_1,  // 4  R6 second slot high
        11'b0_0_0000_0_0_00_0,  // 5  R6 low pair of 1100
        11'b0_0_0000_0_1_11_0,  // 6  R6 high pair of 1100
        11'b0_0_0000_0_0_00_0,  // 7  R7 drained
        11'b0_0_0000_0_0_00_0,  // 8  R7 idle
        11'b1_0_0000_0_1_00_0,  // 9  R2 new event
        11'b1_1_0101_0_1_00_0,  // 10 R3 pad slot, nothing queued
        11'b1_0_0000_0_1_01_0,  // 11 R4 low pair of 0101
        11'b0_0_0000_0_1_01_0,  // 12 R5 carrier lost mid nibble, held
        11'b0_0_0000_0_0_00_0,  // 13 R7 fall at first slot
        11'b0_0_0000_0_0_00_0,  // 14 R7 idle
        11'b1_0_0000_0_1_00_0,  // 15 R8 false carrier
        11'b1_0_0000_0_1_00_0,  // 16 R8
        11'b1_0_0000_0_1_00_0,  // 17 R8
        11'b0_0_0000_0_0_00_0,  // 18 R8 ends at once
        11'b0_0_0000_0_0_00_0,  // 19 R7 idle
        11'b0_1_1111_1_0_00_0,  // 20 R11 strobe without carrier
        11'b0_0_0000_0_0_00_0,  // 21 R11 still idle
        11'b1_0_0000_0_1_00_0,  // 22 R11 open event
        11'b0_0_0000_0_0_00_0   // 23 R11 dropped nibble never appears
    };

    function automatic string row_tag(input int i);
        case (i)
            0:                       return "R2";
            1, 2, 11:                return "R4";
            3, 4, 5, 6:              return "R6";
            7, 8, 13, 14, 19:        return "R7";
            9:                       return "R2";
            10:                      return "R3";
            12:                      return "R5";
            15, 16, 17, 18:          return "R8";
            default:                 return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic crs_e,
                       input logic [1:0] rxd_e, input logic er_e);
        tests++;
        if (crs !== crs_e || rxd !== rxd_e || er !== er_e) begin
            fails++;
            $display("FAIL %s t=%0t: crs_dv=%b rxd=%b rx_er=%b expected crs_dv=%b rxd=%b rx_er=%b",
                     req, $time, crs, rxd, er, crs_e, rxd_e, er_e);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; spd10 = 1'b0; car = 1'b0; vld = 1'b0; nib = '0; nerr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 2'b00, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", 1'b0, 2'b00, 1'b0);

        // 100 Mb/s vector table.
        for (int i = 0; i < NROWS; i++) begin
            {car, vld, nib, nerr} = TBL[i][10:4];
            step();
            chk(row_tag(i), TBL[i][3], TBL[i][2:1], TBL[i][0]);
            if (i == 3) begin
                tests++;
                if (er_n !== 1'b0) begin
                    fails++;
                    $display("FAIL R12 no-error variant: rx_er=%b expected 0", er_n);
                end
            end
        end
        car = 1'b0; vld = 1'b0;
        step();

        // 10 Mb/s: slot length, drain toggle, speed held within the event.
        spd10 = 1'b1; car = 1'b1; vld = 1'b1; nib = 4'b1110; nerr = 1'b0;
        step();
        chk("R2 slow start", 1'b1, 2'b00, 1'b0);
        car = 1'b0; vld = 1'b0;
        for (int k = 1; k <= 30; k++) begin
            step();
            if (k == 2) spd10 = 1'b0;
            if (k == 9)  chk("R9 R5 held to boundary", 1'b1, 2'b00, 1'b0);
            if (k == 10) chk("R9 R6 first slot",       1'b0, 2'b10, 1'b0);
            if (k == 19) chk("R9 R10 slot held",       1'b0, 2'b10, 1'b0);
            if (k == 20) chk("R9 R6 second slot",      1'b1, 2'b11, 1'b0);
            if (k == 29) chk("R9 second held",         1'b1, 2'b11, 1'b0);
            if (k == 30) chk("R7 R9 slow drain end",   1'b0, 2'b00, 1'b0);
        end
        step();

        // 10 Mb/s: carrier returns in mid slot while draining.
        spd10 = 1'b1; car = 1'b1; vld = 1'b1; nib = 4'b0100;
        step();
        car = 1'b0; vld = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            step();
            if (k == 12) begin
                chk("R6 slow first slot low", 1'b0, 2'b00, 1'b0);
                car = 1'b1;
            end
            if (k == 13) chk("R2 mid-slot rise", 1'b1, 2'b00, 1'b0);
            if (k == 20) chk("R4 R9 high pair", 1'b1, 2'b01, 1'b0);
            if (k == 30) begin
                chk("R3 R8 carrier, empty queue", 1'b1, 2'b00, 1'b0);
                car = 1'b0;
            end
            if (k == 39) chk("R5 held until boundary", 1'b1, 2'b00, 1'b0);
            if (k == 40) chk("R7 slow end", 1'b0, 2'b00, 1'b0);
        end
        spd10 = 1'b0;
        step();

        // Reset in the middle of an event.
        car = 1'b1; vld = 1'b1; nib = 4'b1011; nerr = 1'b1;
        step();
        step();
        chk("R12 error with nibble", 1'b1, 2'b11, 1'b1);
        rst_n = 1'b0;
        step();
        chk("R1 reset mid event", 1'b0, 2'b00, 1'b0);
        car = 1'b0; vld = 1'b0; nerr = 1'b0;
        rst_n = 1'b1;
        step();
        step();
        chk("R1 idle after reset", 1'b0, 2'b00, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule